// File: doc/BRIEF.md
# Serially Configured Programmable Logic Array

This block is a sum-of-products logic array whose connections are set at run time. A parameter set fixes the number of inputs, the number of shared product terms and the number of outputs. Each product term may take any input in true or inverted form. Each output ORs any chosen subset of the product terms, and a per-output polarity bit can invert the result. Outputs can therefore be built in plain AND-OR form or in AND-OR-invert form.

The connection map is loaded one bit per clock through a serial port into a staging register. A separate commit pulse copies the staging register into the active map in a single cycle. The logic path from the data inputs to the outputs is purely combinational and reads only the active map, so a partly loaded map never reaches the outputs. The block also reports how many serial bits arrived before the most recent commit. Software can use this count to confirm that a load had the intended length.

Top module: `pla_fabric`

## Requirements
- R1: While reset is high, and on the first clock edge after reset, the active map and the length readback are zero. With an all-zero active map, every output is 0 for any input.
- R2: Bit positions in the map: product term t, input i, true form is at bit t*2*N_IN + 2*i, and the inverted form is at the next bit up. A set bit means connected. A product term is the AND of its connected literals.
- R3: OR-plane bits begin at AND_W = N_TERM*2*N_IN. Bit AND_W + o*N_TERM + t connects term t to output o. One term may feed several outputs.
- R4: The polarity bit of output o is at AND_W + N_OUT*N_TERM + o. When that bit is 1, output o is the inverse of its OR result.
- R5: A serial bit is shifted in on each edge where the shift enable is high, least significant bit first. The first bit of a CFG_W-bit stream lands at bit 0. Bits shifted earlier than the last CFG_W are lost. Shifting alone never changes the outputs.
- R6: A commit pulse copies the staging register into the active map in one cycle. Without a commit, the active map holds its value.
- R7: A product term with no connected literals evaluates to 1. A product term that has both literals of any one input connected evaluates to 0.
- R8: An output with no product terms connected has an OR result of 0, so the output equals its polarity bit.
- R9: On a commit, the length readback captures the number of bits shifted since the previous commit or reset. The count saturates at 2^LEN_W-1. The readback holds its value between commits.
- R10: When the shift enable is low, the serial data input is ignored.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock for the configuration logic |
| rst | input | 1 | Synchronous active-high reset |
| cfg_shift_en | input | 1 | Shift one map bit on this edge |
| cfg_din | input | 1 | Serial map bit |
| cfg_commit | input | 1 | Copy the staging register to the active map |
| pla_in | input | N_IN | Logic inputs |
| pla_out | output | N_OUT | Logic outputs, combinational from pla_in |
| cfg_len | output | LEN_W | Number of bits shifted before the last commit |

## Verification
A wrong fuse in the active map shows up on the outputs only for the input patterns that exercise that literal or term. The bench therefore sweeps a full code-converter program across all its valid inputs and also runs degenerate programs. A staging or commit fault appears on the outputs in the first sample after the commit edge, or as an early change while bits are still shifting. A wrong bit-ordering shows up as wrong output values after a load with extra leading bits. A counter fault shows up on the length readback right after the commit that captures it.

// File: rtl/pla_pkg.sv
package pla_pkg;
  function automatic int and_bits(input int n_in, input int n_term);
    return n_term * 2 * n_in;
  endfunction

  function automatic int or_bits(input int n_term, input int n_out);
    return n_out * n_term;
  endfunction

  function automatic int map_bits(input int n_in, input int n_term, input int n_out);
    return and_bits(n_in, n_term) + or_bits(n_term, n_out) + n_out;
  endfunction
endpackage

// File: rtl/pla_cfg_store.sv
module pla_cfg_store #(
  parameter int CFG_W = 112,
  parameter int LEN_W = 8
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             shift_en,
  input  logic             din,
  input  logic             commit,
  output logic [CFG_W-1:0] shadow,
  output logic [CFG_W-1:0] active,
  output logic [LEN_W-1:0] len
);
  localparam logic [LEN_W-1:0] LEN_MAX = '1;

  logic [LEN_W-1:0] cnt_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      shadow <= '0;
      active <= '0;
    end else begin
      if (shift_en) shadow <= {din, shadow[CFG_W-1:1]};
      if (commit)   active <= shadow;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt_q <= '0;
      len   <= '0;
    end else if (commit) begin
      len   <= cnt_q;
      cnt_q <= shift_en ? LEN_W'(1) : '0;
    end else if (shift_en && cnt_q != LEN_MAX) begin
      cnt_q <= cnt_q + LEN_W'(1);
    end
  end
endmodule

// File: rtl/pla_and_plane.sv
module pla_and_plane #(
  parameter int N_IN   = 4,
  parameter int N_TERM = 9
) (
  input  logic [N_TERM*2*N_IN-1:0] fuse,
  input  logic [N_IN-1:0]          x,
  output logic [N_TERM-1:0]        term
);
  localparam int ROW_W = 2 * N_IN;

  for (genvar t = 0; t < N_TERM; t++) begin : g_term
    logic [N_IN-1:0] lit_ok;
    for (genvar i = 0; i < N_IN; i++) begin : g_lit
      // an unconnected literal passes; a connected one must be satisfied
      assign lit_ok[i] = (~fuse[t*ROW_W + 2*i]     |  x[i]) &
                         (~fuse[t*ROW_W + 2*i + 1] | ~x[i]);
    end
    assign term[t] = &lit_ok;
  end
endmodule

// File: rtl/pla_or_plane.sv
module pla_or_plane #(
  parameter int N_TERM = 9,
  parameter int N_OUT  = 4
) (
  input  logic [N_OUT*N_TERM-1:0] fuse,
  input  logic [N_TERM-1:0]       term,
  input  logic [N_OUT-1:0]        pol,
  output logic [N_OUT-1:0]        y
);
  for (genvar o = 0; o < N_OUT; o++) begin : g_sum
    logic sum;
    assign sum  = |(term & fuse[o*N_TERM +: N_TERM]);
    assign y[o] = sum ^ pol[o];
  end
endmodule

// File: rtl/pla_fabric.sv
module pla_fabric #(
  parameter int N_IN   = 4,
  parameter int N_TERM = 9,
  parameter int N_OUT  = 4,
  parameter int AND_W  = pla_pkg::and_bits(N_IN, N_TERM),
  parameter int OR_W   = pla_pkg::or_bits(N_TERM, N_OUT),
  parameter int CFG_W  = pla_pkg::map_bits(N_IN, N_TERM, N_OUT),
  parameter int LEN_W  = $clog2(CFG_W + 1) + 1
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             cfg_shift_en,
  input  logic             cfg_din,
  input  logic             cfg_commit,
  input  logic [N_IN-1:0]  pla_in,
  output logic [N_OUT-1:0] pla_out,
  output logic [LEN_W-1:0] cfg_len
);
  logic [CFG_W-1:0]  shadow_q;
  logic [CFG_W-1:0]  active_q;
  logic [N_TERM-1:0] term;

  pla_cfg_store #(.CFG_W(CFG_W), .LEN_W(LEN_W)) u_store (
    .clk(clk), .rst(rst), .shift_en(cfg_shift_en), .din(cfg_din),
    .commit(cfg_commit), .shadow(shadow_q), .active(active_q), .len(cfg_len)
  );

  pla_and_plane #(.N_IN(N_IN), .N_TERM(N_TERM)) u_and (
    .fuse(active_q[AND_W-1:0]), .x(pla_in), .term(term)
  );

  pla_or_plane #(.N_TERM(N_TERM), .N_OUT(N_OUT)) u_or (
    .fuse(active_q[AND_W +: OR_W]), .term(term),
    .pol(active_q[AND_W+OR_W +: N_OUT]), .y(pla_out)
  );
endmodule

// File: rtl/pla_fabric_chk.sv
module pla_fabric_chk #(
  parameter int CFG_W = 112,
  parameter int N_OUT = 4,
  parameter int LEN_W = 8
) (
  input logic             clk,
  input logic             rst,
  input logic             cfg_commit,
  input logic [CFG_W-1:0] shadow,
  input logic [CFG_W-1:0] active,
  input logic [N_OUT-1:0] pla_out,
  input logic [LEN_W-1:0] cfg_len
);
  AST_RST_CLEAR: assert property (@(posedge clk) rst |=> (active == '0 && cfg_len == '0)); // R1
  AST_ZERO_MAP_OUT: assert property (@(posedge clk) disable iff (rst) (active == '0) |-> (pla_out == '0)); // R1
  AST_MAP_HOLD: assert property (@(posedge clk) disable iff (rst) !cfg_commit |=> $stable(active)); // R6
  AST_MAP_COPY: assert property (@(posedge clk) disable iff (rst) cfg_commit |=> (active == $past(shadow))); // R6
  AST_LEN_HOLD: assert property (@(posedge clk) disable iff (rst) !cfg_commit |=> $stable(cfg_len)); // R9
endmodule

bind pla_fabric pla_fabric_chk #(.CFG_W(CFG_W), .N_OUT(N_OUT), .LEN_W(LEN_W)) u_chk (
  .clk(clk), .rst(rst), .cfg_commit(cfg_commit), .shadow(shadow_q),
  .active(active_q), .pla_out(pla_out), .cfg_len(cfg_len)
);

// File: tb/pla_fabric_tb.sv
module pla_fabric_tb;
  localparam int N_IN = 4, N_TERM = 9, N_OUT = 4;
  localparam int AND_W = N_TERM * 2 * N_IN;
  localparam int OR_W  = N_OUT * N_TERM;
  localparam int CFG_W = AND_W + OR_W + N_OUT;
  localparam int LEN_W = $clog2(CFG_W + 1) + 1;

  // {input, expected output} for the decimal-to-excess-3 program
  localparam logic [7:0] VEC [0:9] = '{8'h03, 8'h14, 8'h25, 8'h36, 8'h47,
                                       8'h58, 8'h69, 8'h7A, 8'h8B, 8'h9C};

  logic clk = 0, rst = 1, sh = 0, din = 0, cm = 0;
  logic [N_IN-1:0] pin = '0;
  logic [N_OUT-1:0] pout;
  logic [LEN_W-1:0] clen;
  int errs = 0, chks = 0;
  logic done = 0;
  logic [CFG_W-1:0] cfg, cfg_bcd;

  always #5 clk = ~clk;

  pla_fabric u_dut (.clk(clk), .rst(rst), .cfg_shift_en(sh), .cfg_din(din),
                    .cfg_commit(cm), .pla_in(pin), .pla_out(pout), .cfg_len(clen));

  task automatic check(input string req, input int act, input int exp);
    chks++;
    if (act != exp) begin
      errs++;
      $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic lit(input int t, input int i, input int neg);
    cfg[t*2*N_IN + 2*i + neg] = 1'b1;
  endtask
  task automatic conn(input int o, input int t);
    cfg[AND_W + o*N_TERM + t] = 1'b1;
  endtask
  task automatic pol(input int o);
    cfg[AND_W + OR_W + o] = 1'b1;
  endtask

  task automatic shift_const(input logic b, input int n);
    for (int k = 0; k < n; k++) begin
      @(negedge clk); sh = 1; din = b;
    end
    @(negedge clk); sh = 0; din = 0;
  endtask
  task automatic shift_map(input logic [CFG_W-1:0] m);
    for (int k = 0; k < CFG_W; k++) begin
      @(negedge clk); sh = 1; din = m[k];
    end
    @(negedge clk); sh = 0; din = 0;
  endtask
  task automatic commit();
    @(negedge clk); cm = 1;
    @(negedge clk); cm = 0;
  endtask
  task automatic probe(input logic [N_IN-1:0] x, input int exp, input string req);
    pin = x; #1;
    check(req, int'(pout), exp);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      errs++; chks++;
      $display("FAIL watchdog: actual=timeout expected=finish");
      $display("Result: errors=%0d of %0d checks", errs, chks);
      $finish;
    end
  end

  initial begin
    // inputs: bit3=A bit2=B bit1=C bit0=D
    cfg = '0;
    lit(0,3,0);
    lit(1,2,0); lit(1,1,0);
    lit(2,2,0); lit(2,0,0);
    lit(3,2,0); lit(3,1,1); lit(3,0,1);
    lit(4,2,1); lit(4,1,0);
    lit(5,2,1); lit(5,0,0);
    lit(6,1,1); lit(6,0,1);
    lit(7,1,0); lit(7,0,0);
    lit(8,0,1);
    conn(3,0); conn(3,1); conn(3,2);
    conn(2,3); conn(2,4); conn(2,5);
    conn(1,6); conn(1,7);
    conn(0,8);
    cfg_bcd = cfg;

    repeat (3) @(negedge clk);
    rst = 0;
    probe(4'd5, 0, "R1 reset out");
    check("R1 reset len", int'(clen), 0);

    shift_const(1'b1, 10);
    probe(4'd5, 0, "R5 no effect before commit");
    shift_map(cfg_bcd);
    commit();
    check("R9 len after 10+CFG_W", int'(clen), 10 + CFG_W);

    for (int v = 0; v < 10; v++)
      probe(VEC[v][7:4], int'(VEC[v][3:0]), "R2 R3 table");

    // serial data toggled with enable low
    for (int k = 0; k < 6; k++) begin
      @(negedge clk); din = k[0];
    end
    commit();
    probe(4'd9, 12, "R10 data ignored");
    check("R9 len no shifts", int'(clen), 0);

    cfg = cfg_bcd;
    for (int o = 0; o < N_OUT; o++) pol(o);
    shift_map(cfg);
    probe(4'd2, 5, "R5 old map kept while shifting");
    commit();
    probe(4'd0, 12, "R4 inverted 0");
    probe(4'd7, 5, "R4 inverted 7");
    probe(4'd9, 3, "R4 inverted 9");

    // degenerate program: empty term, contradictory term, empty outputs
    cfg = '0;
    conn(0,0);
    lit(1,0,0); lit(1,0,1); conn(1,1);
    pol(3);
    shift_map(cfg);
    commit();
    probe(4'd0, 9, "R7 R8 in=0");
    probe(4'd7, 9, "R7 R8 in=7");
    probe(4'd15, 9, "R7 R8 in=15");

    shift_const(1'b1, 5);
    shift_map(cfg_bcd);
    commit();
    probe(4'd1, 4, "R5 leading bits dropped");
    check("R9 len 5+CFG_W", int'(clen), 5 + CFG_W);

    shift_const(1'b0, 300);
    commit();
    check("R9 len saturates", int'(clen), (1 << LEN_W) - 1);
    probe(4'd3, 0, "R6 zero map committed");

    shift_map(cfg_bcd);
    commit();
    probe(4'd4, 7, "R6 reload");
    @(negedge clk); rst = 1;
    @(negedge clk); rst = 0;
    probe(4'd4, 0, "R1 reset clears map");
    check("R1 reset clears len", int'(clen), 0);

    done = 1;
    $display("Result: errors=%0d of %0d checks", errs, chks);
    $finish;
  end
endmodule